// File: doc/BRIEF.md
# Flash Group Burst Programming Controller

This block commits a group of eight staged 32-bit words to a non-volatile memory array with a single command. Software writes a target address and the eight staging registers over a small register bus. It then sets the write-enable bit in the control register. A second control write carries the go bit and the burst operation code. While the controller is busy it pushes the staged words to consecutive word addresses of the array port, one handshake per word. It then drops the busy bit and leaves error flags for software to read.

Before the first word goes out, the controller checks two things. The target page must not be write-protected. No word of the group may have been programmed since the last array erase. The controller keeps one flag per array word for the second check. A low-voltage warning at any point while busy aborts the rest of the burst.

Top module: `flash_burst_prog`

## Requirements
- R1: After reset the control register reads 0x00000000 and the array strobe `mem_we` is low.
- R2: A control write with bit 15 (go) set and bits [3:0] equal to 0x2 starts a burst. The stored write-enable bit 14 must already be 1 from an earlier write. Staging register k (bus index 2+k) then goes to word address base+4k, in ascending k.
- R3: The base is the address register (bus index 1) with bits [4:0] forced to zero, so any low-order bits written there are ignored.
- R4: A go write does not start a burst when the stored write-enable is 0 or when bits [3:0] differ from 0x2. Busy stays 0 and no array write occurs.
- R5: Bit 15 of the control register reads 1 from the cycle after the go write until the array accepts the last word, and reads 0 after that.
- R6: Each word is presented with `mem_we` high, and its address and data are held stable until `mem_rdy` is seen high.
- R7: If the base falls in a page whose `wp_mask` bit is 1, the controller sets the write error, bit 13, and performs no array write. Pages are 128 bytes, so the page is base[9:7].
- R8: If any word of the target group has been programmed since the last erase, the controller sets bit 13 and performs no array write. This holds even when the new data would only clear bits.
- R9: A one-cycle pulse on `erase_all` forgets every programmed-word mark, so any group can be programmed again.
- R10: While busy, bus writes to the address, staging and control registers have no effect.
- R11: If `lv_in` is high at a clock edge while busy, the remaining words are abandoned, busy drops and the low-voltage error, bit 12, is set. Words accepted before the abort stay marked as programmed.
- R12: A go write that starts a burst clears both error bits 12 and 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; data appears on `bus_rdata` one cycle later |
| bus_addr | input | 4 | Register index: 0 control, 1 address, 2..9 staging words |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| wp_mask | input | 8 | One write-protect bit per 128-byte page |
| lv_in | input | 1 | Low-voltage warning |
| erase_all | input | 1 | Clears all programmed-word marks |
| mem_we | output | 1 | Array write strobe, held until accepted |
| mem_addr | output | 10 | Array byte address of the presented word |
| mem_wdata | output | 32 | Array write data |
| mem_rdy | input | 1 | Array accepts the presented word when high with `mem_we` |

## Verification
The go write is latched at one edge, and busy reads back set on the read issued after it. The group check happens one edge later. The first strobe is visible after that edge, and every later word follows at the edge after the previous one is accepted. The bench records each array handshake one nanosecond before the edge that completes it, reading `mem_we`, `mem_rdy` and `lv_in` together. Because of this the log counts exactly the words the design accepts, and an abort raised at a given negative edge is never logged as an extra word. Error and busy bits are checked only through control reads made after polling shows busy low. Register reads always sample `bus_rdata` one full cycle after the read strobe.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  localparam int OP_W      = 4;
  localparam logic [OP_W-1:0] OP_BURST = 4'h2;
  localparam int BIT_LVERR = 12;
  localparam int BIT_WERR  = 13;
  localparam int BIT_WEN   = 14;
  localparam int BIT_BUSY  = 15;
  localparam int IDX_CTRL  = 0;
  localparam int IDX_ADDR  = 1;
  localparam int IDX_DATA0 = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fbp_regs.sv
module fbp_regs
  import fbp_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int GROUP_WORDS = 8,
  parameter int RIDX_W      = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_we,
  input  logic                          bus_re,
  input  logic [RIDX_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic                          busy,
  input  logic                          werr,
  input  logic                          lverr,
  output logic                          start,
  output logic [ADDR_W-1:0]             addr_q,
  output logic [GROUP_WORDS*DATA_W-1:0] data_flat
);
  localparam logic [RIDX_W-1:0] CTRL_IX = RIDX_W'(IDX_CTRL);
  localparam logic [RIDX_W-1:0] ADDR_IX = RIDX_W'(IDX_ADDR);

  logic              wr_ok;
  logic [OP_W-1:0]   op_q;
  logic              wen_q;
  logic [DATA_W-1:0] stage_q [GROUP_WORDS];
  logic [DATA_W-1:0] ctrl_v;
  logic [DATA_W-1:0] rd_v;

  assign wr_ok = bus_we && !busy;

  // burst launches only from a previously stored enable
  assign start = wr_ok && (bus_addr == CTRL_IX) && bus_wdata[BIT_BUSY]
                 && wen_q && (bus_wdata[OP_W-1:0] == OP_BURST);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= '0;
      wen_q  <= 1'b0;
      addr_q <= '0;
    end else if (wr_ok) begin
      if (bus_addr == CTRL_IX) begin
        op_q  <= bus_wdata[OP_W-1:0];
        wen_q <= bus_wdata[BIT_WEN];
      end
      if (bus_addr == ADDR_IX) begin
        addr_q <= bus_wdata[ADDR_W-1:0];
      end
    end
  end

  for (genvar k = 0; k < GROUP_WORDS; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[k] <= '0;
      end else if (wr_ok && bus_addr == RIDX_W'(IDX_DATA0 + k)) begin
        stage_q[k] <= bus_wdata;
      end
    end
    assign data_flat[k*DATA_W +: DATA_W] = stage_q[k];
  end

  always_comb begin
    ctrl_v              = '0;
    ctrl_v[OP_W-1:0]    = op_q;
    ctrl_v[BIT_LVERR]   = lverr;
    ctrl_v[BIT_WERR]    = werr;
    ctrl_v[BIT_WEN]     = wen_q;
    ctrl_v[BIT_BUSY]    = busy;
  end

  always_comb begin
    rd_v = '0;
    if (bus_addr == CTRL_IX) rd_v = ctrl_v;
    if (bus_addr == ADDR_IX) rd_v = DATA_W'(addr_q);
    for (int k = 0; k < GROUP_WORDS; k++) begin
      if (bus_addr == RIDX_W'(IDX_DATA0 + k)) rd_v = stage_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      bus_rdata <= rd_v;
    end
  end
endmodule

// File: rtl/fbp_progmap.sv
module fbp_progmap #(
  parameter int NWORDS      = 256,
  parameter int GROUP_WORDS = 8,
  parameter int GRP_W       = 5,
  parameter int WIDX_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase_all,
  input  logic              mark_en,
  input  logic [WIDX_W-1:0] mark_idx,
  input  logic [GRP_W-1:0]  grp_sel,
  output logic              grp_used
);
  logic [NWORDS-1:0] done_q;

  always_ff @(posedge clk) begin
    if (rst || erase_all) begin
      done_q <= '0;
    end else if (mark_en) begin
      done_q[mark_idx] <= 1'b1;
    end
  end

  assign grp_used = |done_q[grp_sel*GROUP_WORDS +: GROUP_WORDS];
endmodule

// File: rtl/fbp_seq.sv
module fbp_seq
  import fbp_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int GROUP_WORDS = 8,
  parameter int WIDX_W      = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [ADDR_W-1:0]             base_addr,
  input  logic [GROUP_WORDS*DATA_W-1:0] data_flat,
  input  logic                          page_locked,
  input  logic                          grp_used,
  input  logic                          lv_in,
  input  logic                          mem_rdy,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [DATA_W-1:0]             mem_wdata,
  output logic                          busy,
  output logic                          werr,
  output logic                          lverr,
  output logic                          mark_en,
  output logic [WIDX_W-1:0]             mark_idx
);
  localparam int IDX_W      = (GROUP_WORDS > 1) ? $clog2(GROUP_WORDS) : 1;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WORD_LSB   = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
  localparam logic [IDX_W-1:0]  LAST = IDX_W'(GROUP_WORDS - 1);

  seq_state_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_nx;
  logic             take;

  assign idx_nx   = idx_q + 1'b1;
  assign take     = (st_q == ST_WRITE) && mem_rdy && !lv_in;
  assign mark_en  = take;
  assign mark_idx = mem_addr[ADDR_W-1:WORD_LSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      busy      <= 1'b0;
      werr      <= 1'b0;
      lverr     <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      idx_q     <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            busy  <= 1'b1;
            werr  <= 1'b0;
            lverr <= 1'b0;
            st_q  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (lv_in) begin
            lverr <= 1'b1;
            busy  <= 1'b0;
            st_q  <= ST_IDLE;
          end else if (page_locked || grp_used) begin
            werr <= 1'b1;
            busy <= 1'b0;
            st_q <= ST_IDLE;
          end else begin
            mem_we    <= 1'b1;
            mem_addr  <= base_addr;
            mem_wdata <= data_flat[0 +: DATA_W];
            idx_q     <= '0;
            st_q      <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (lv_in) begin
            lverr  <= 1'b1;
            busy   <= 1'b0;
            mem_we <= 1'b0;
            st_q   <= ST_IDLE;
          end else if (mem_rdy) begin
            if (idx_q == LAST) begin
              mem_we <= 1'b0;
              busy   <= 1'b0;
              st_q   <= ST_IDLE;
            end else begin
              idx_q     <= idx_nx;
              mem_addr  <= mem_addr + STEP;
              mem_wdata <= data_flat[idx_nx*DATA_W +: DATA_W];
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_burst_prog.sv
module flash_burst_prog
  import fbp_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int GROUP_WORDS = 8,
  parameter int PAGE_BYTES  = 128,
  parameter int RIDX_W      = 4
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        bus_we,
  input  logic                                        bus_re,
  input  logic [RIDX_W-1:0]                           bus_addr,
  input  logic [DATA_W-1:0]                           bus_wdata,
  output logic [DATA_W-1:0]                           bus_rdata,
  input  logic [(1<<(ADDR_W-$clog2(PAGE_BYTES)))-1:0] wp_mask,
  input  logic                                        lv_in,
  input  logic                                        erase_all,
  output logic                                        mem_we,
  output logic [ADDR_W-1:0]                           mem_addr,
  output logic [DATA_W-1:0]                           mem_wdata,
  input  logic                                        mem_rdy
);
  localparam int WORD_LSB = $clog2(DATA_W / 8);
  localparam int GLSB     = WORD_LSB + $clog2(GROUP_WORDS);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam int GRP_W    = ADDR_W - GLSB;
  localparam int WIDX_W   = ADDR_W - WORD_LSB;
  localparam int NWORDS   = 1 << WIDX_W;

  logic                          start_w;
  logic                          busy_w;
  logic                          werr_w;
  logic                          lverr_w;
  logic [ADDR_W-1:0]             addr_w;
  logic [ADDR_W-1:0]             base_w;
  logic [GROUP_WORDS*DATA_W-1:0] data_w;
  logic                          locked_w;
  logic                          used_w;
  logic                          mark_en_w;
  logic [WIDX_W-1:0]             mark_idx_w;

  assign base_w   = {addr_w[ADDR_W-1:GLSB], {GLSB{1'b0}}};
  assign locked_w = wp_mask[addr_w[ADDR_W-1:PAGE_LSB]];

  fbp_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .GROUP_WORDS(GROUP_WORDS), .RIDX_W(RIDX_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy_w), .werr(werr_w), .lverr(lverr_w),
    .start(start_w), .addr_q(addr_w), .data_flat(data_w)
  );

  fbp_progmap #(
    .NWORDS(NWORDS), .GROUP_WORDS(GROUP_WORDS),
    .GRP_W(GRP_W), .WIDX_W(WIDX_W)
  ) u_map (
    .clk(clk), .rst(rst), .erase_all(erase_all),
    .mark_en(mark_en_w), .mark_idx(mark_idx_w),
    .grp_sel(addr_w[ADDR_W-1:GLSB]), .grp_used(used_w)
  );

  fbp_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .GROUP_WORDS(GROUP_WORDS), .WIDX_W(WIDX_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start_w),
    .base_addr(base_w), .data_flat(data_w),
    .page_locked(locked_w), .grp_used(used_w),
    .lv_in(lv_in), .mem_rdy(mem_rdy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy_w), .werr(werr_w), .lverr(lverr_w),
    .mark_en(mark_en_w), .mark_idx(mark_idx_w)
  );
endmodule

// File: rtl/fbp_checker.sv
module fbp_checker #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int GROUP_WORDS = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          start,
  input logic                          busy,
  input logic                          lverr,
  input logic                          lv_in,
  input logic                          mem_we,
  input logic                          mem_rdy,
  input logic [ADDR_W-1:0]             mem_addr,
  input logic [DATA_W-1:0]             mem_wdata,
  input logic [ADDR_W-1:0]             addr_q,
  input logic [GROUP_WORDS*DATA_W-1:0] data_flat
);
  localparam int WORD_LSB = $clog2(DATA_W / 8);
  localparam int GLSB     = WORD_LSB + $clog2(GROUP_WORDS);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_rdy && !lv_in) |=> (!mem_we || mem_addr == $past(mem_addr) + STEP));

  assert_word_align_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[WORD_LSB-1:0] == '0));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_we);

  assert_last_done_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_rdy && !lv_in && (&mem_addr[GLSB-1:WORD_LSB])) |=> !busy);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_rdy && !lv_in) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));

  assert_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(addr_q) && $stable(data_flat)));

  assert_lv_abort_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && lv_in) |=> (!busy && !mem_we && lverr));
endmodule

bind flash_burst_prog fbp_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GROUP_WORDS(GROUP_WORDS)
) u_chk (
  .clk(clk), .rst(rst), .start(start_w), .busy(busy_w), .lverr(lverr_w),
  .lv_in(lv_in), .mem_we(mem_we), .mem_rdy(mem_rdy),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .addr_q(addr_w), .data_flat(data_w)
);

// File: tb/flash_burst_prog_bench.sv
`timescale 1ns/1ps
module flash_burst_prog_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  wp_mask = '0;
  logic        lv_in = 1'b0, erase_all = 1'b0;
  logic        mem_we, mem_rdy = 1'b0;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata;

  int n_chk = 0, n_fail = 0;
  int rdy_mode = 2;
  int wr_cnt = 0;
  logic [9:0]  wr_a [64];
  logic [31:0] wr_d [64];
  logic [31:0] cur_d [8];
  bit          prog_m [256];
  logic [9:0]  exp_base;
  bit          exp_bad;

  flash_burst_prog u_flash_burst_prog (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wp_mask(wp_mask),
    .lv_in(lv_in), .erase_all(erase_all), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdy(mem_rdy)
  );

  initial forever #2 clk = ~clk;

  always @(negedge clk) begin
    case (rdy_mode)
      0:       mem_rdy <= 1'b0;
      1:       mem_rdy <= 1'b1;
      default: mem_rdy <= ($urandom % 3) != 0;
    endcase
  end

  // handshake log, sampled 1 ns before the edge that completes it
  always begin
    @(negedge clk);
    #1;
    if (!rst && mem_we && mem_rdy && !lv_in) begin
      if (wr_cnt < 64) begin
        wr_a[wr_cnt] = mem_addr;
        wr_d[wr_cnt] = mem_wdata;
      end
      wr_cnt = wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] ix, input logic [31:0] v);
    @(negedge clk); bus_we = 1'b1; bus_addr = ix; bus_wdata = v;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] ix, output logic [31:0] v);
    @(negedge clk); bus_re = 1'b1; bus_addr = ix;
    @(negedge clk); bus_re = 1'b0; v = bus_rdata;
  endtask

  function automatic bit group_bad(input logic [9:0] b);
    bit u = wp_mask[b[9:7]];
    for (int k = 0; k < 8; k++) if (prog_m[b[9:2] + k]) u = 1'b1;
    return u;
  endfunction

  task automatic pulse_erase();
    @(negedge clk); erase_all = 1'b1;
    @(negedge clk); erase_all = 1'b0;
    for (int i = 0; i < 256; i++) prog_m[i] = 1'b0;
  endtask

  task automatic start_op(input logic [31:0] a);
    bus_wr(4'd1, a);
    for (int k = 0; k < 8; k++) bus_wr(4'(2 + k), cur_d[k]);
    bus_wr(4'd0, 32'h0000_4002);
    exp_base = a[9:0] & 10'h3E0;
    exp_bad  = group_bad(exp_base);
    wr_cnt   = 0;
    bus_wr(4'd0, 32'h0000_C002);
  endtask

  task automatic wait_idle(output logic [31:0] c);
    c = 32'h8000;
    for (int i = 0; i < 400 && c[15]; i++) bus_rd(4'd0, c);
  endtask

  task automatic finish_op(input string tag);
    logic [31:0] c;
    bit a_ok = 1'b1, d_ok = 1'b1;
    wait_idle(c);
    chk(c[15] == 1'b0, {tag, " R5 busy cleared"}, c, 32'h0);
    chk(c[13] == exp_bad, {tag, " R7/R8 write error flag"}, {31'b0, c[13]}, {31'b0, exp_bad});
    chk(c[12] == 1'b0, {tag, " R12 low-voltage flag clear"}, {31'b0, c[12]}, 32'h0);
    chk(wr_cnt == (exp_bad ? 0 : 8), {tag, " R2 word count"}, wr_cnt, exp_bad ? 0 : 8);
    if (!exp_bad && wr_cnt == 8) begin
      for (int k = 0; k < 8; k++) begin
        if (wr_a[k] != exp_base + 10'(4 * k)) a_ok = 1'b0;
        if (wr_d[k] != cur_d[k]) d_ok = 1'b0;
        prog_m[exp_base[9:2] + k] = 1'b1;
      end
      chk(a_ok, {tag, " R2/R3 ascending addresses"}, {22'b0, wr_a[0]}, {22'b0, exp_base});
      chk(d_ok, {tag, " R2/R6 word data"}, wr_d[0], cur_d[0]);
    end
  endtask

  task automatic rand_data();
    for (int k = 0; k < 8; k++) cur_d[k] = $urandom;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R5 watchdog actual=hung expected=complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) prog_m[i] = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(mem_we == 1'b0, "R1 strobe low", {31'b0, mem_we}, 32'h0);
    bus_rd(4'd0, v);
    chk(v == 32'h0, "R1 control reset", v, 32'h0);

    // R4 go without enable, then wrong op code
    bus_wr(4'd0, 32'h0000_8002);
    bus_rd(4'd0, v);
    chk(v == 32'h0000_0002, "R4 no enable no start", v, 32'h0000_0002);
    bus_wr(4'd0, 32'h0000_4003);
    wr_cnt = 0;
    bus_wr(4'd0, 32'h0000_C003);
    repeat (4) @(negedge clk);
    bus_rd(4'd0, v);
    chk(v == 32'h0000_4003, "R4 wrong op no start", v, 32'h0000_4003);
    chk(wr_cnt == 0, "R4 no array write", wr_cnt, 0);

    // R2 R5 R6 basic burst with random ready
    rand_data(); start_op(32'h040); finish_op("basic");
    // R3 low bits ignored
    rand_data(); start_op(32'h09F); finish_op("R3 unaligned");
    // R8 reprogram same group
    rand_data(); start_op(32'h080); finish_op("R8 reprogram");
    // R12 next good op clears error
    rand_data(); start_op(32'h0C0); finish_op("R12 clear");
    // R9 erase then reprogram
    pulse_erase();
    rand_data(); start_op(32'h080); finish_op("R9 after erase");
    // R7 protected page 2
    wp_mask = 8'b0000_0100;
    rand_data(); start_op(32'h100); finish_op("R7 protected");
    wp_mask = 8'h00;

    // R10 writes while busy ignored
    rdy_mode = 0;
    rand_data(); start_op(32'h200);
    bus_wr(4'd1, 32'h300);
    bus_wr(4'd2, ~cur_d[0]);
    bus_wr(4'd0, 32'h0);
    bus_rd(4'd1, v);
    chk(v == 32'h200, "R10 address kept", v, 32'h200);
    bus_rd(4'd0, v);
    chk(v == 32'h0000_C002, "R10 control kept", v, 32'h0000_C002);
    rdy_mode = 2;
    finish_op("R10 busy writes");

    // R11 abort before any word accepted
    rdy_mode = 0;
    rand_data(); start_op(32'h240);
    repeat (3) @(negedge clk);
    lv_in = 1'b1;
    @(negedge clk); lv_in = 1'b0;
    wait_idle(v);
    chk(v == 32'h0000_5002, "R11 abort flags", v, 32'h0000_5002);
    chk(wr_cnt == 0, "R11 no words", wr_cnt, 0);

    // R11 abort after three words
    rdy_mode = 1;
    rand_data(); start_op(32'h260);
    while (wr_cnt < 3) @(negedge clk);
    lv_in = 1'b1;
    @(negedge clk); lv_in = 1'b0;
    wait_idle(v);
    chk(v[12] == 1'b1 && v[15] == 1'b0, "R11 mid abort flag", v, 32'h0000_5002);
    chk(wr_cnt == 3, "R11 partial count", wr_cnt, 3);
    chk(wr_a[2] == 10'h268, "R11 last accepted address", {22'b0, wr_a[2]}, 32'h268);
    for (int k = 0; k < 3; k++) prog_m[(10'h260 >> 2) + k] = 1'b1;
    rdy_mode = 2;
    rand_data(); start_op(32'h240); finish_op("R11/R12 retry");
    rand_data(); start_op(32'h260); finish_op("R11/R8 partial marks");

    // random mix
    for (int it = 0; it < 24; it++) begin
      if ($urandom % 5 == 0) pulse_erase();
      wp_mask = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      rand_data();
      start_op(32'($urandom % 1024));
      finish_op("random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule